// File: doc/BRIEF.md
# Paged Memory Bank Controller

This block sits between an 8-bit processor with a 16-bit address bus and the memory system behind it. Each processor access is steered into one of three regions. The lowest 16 KB is a fixed internal RAM. The next 16 KB is a window that one page-select register switches among seven internal banks. The upper 32 KB is a window onto a 29-bit external address space.

The external address is built from the fifteen low processor address bits plus two page registers. The top three bits of that address name an external bank, and the bank drives one of four active-low chip selects. All three page registers are written, and read back, through the processor's I/O port space. The memory arrays and the external bus timing lie outside the block.

Top module: `pagemap_ctl`

## Requirements
- R1: After reset all three page registers hold zero, so reads of I/O ports 0x01, 0x02 and 0x05 return 0x00.
- R2: An access to 0x0000–0x3FFF raises `fix_sel` only: no bank strobe, no chip select, no bus error, whatever the page registers hold.
- R3: An access to 0x4000–0x7FFF with page-select code 0–6 raises only `bank_stb[code]`. Code order: 0 USB-transfer RAM, 1/2/3 DSP program memory high/middle/low byte, 4/5/6 DSP data memory high/middle/low byte. `mem_off` is address bits 13:0 and `win_rdata` passes `bank_rdata`.
- R4: With code 0, the 4 KB USB-transfer bank covers only 0x4000–0x4FFF. Window accesses at 0x5000–0x7FFF raise no strobe, raise `win_void`, and `win_rdata` reads 0xFF.
- R5: Page-select codes 7–255 select no bank. A window access then raises `win_void`, and `win_rdata` reads 0xFF.
- R6: `ext_addr[14:0]` equals processor address bits 14:0. `ext_addr[22:15]` is the low page register (port 0x01). `ext_addr[28:23]` is bits 5:0 of the high page register (port 0x02).
- R7: An access to 0x8000–0xFFFF takes its bank from `ext_addr[28:26]`. Bank 0–3 drives `cs_n[bank]` low and leaves the other chip selects high. So external address 0x04000000 asserts `cs_n[1]` and 0x08000000 asserts `cs_n[2]`.
- R8: An extended access whose bank is 4–7 drives no chip select and raises `bus_err` for that cycle.
- R9: An I/O write updates its register at the next clock edge. An access in the cycle of the write still uses the old value. The high register reads back with bits 7:6 as zero. Any port other than 0x01, 0x02 or 0x05 reads 0xFF.
- R10: With neither `cpu_rd` nor `cpu_wr` asserted, `fix_sel`, `bank_stb`, `win_void` and `bus_err` are low and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Memory read request |
| cpu_wr | input | 1 | Memory write request |
| bank_rdata | input | 8 | Read data from the selected internal bank |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O readback of the addressed register |
| fix_sel | output | 1 | Fixed RAM select |
| bank_stb | output | 7 | One strobe per internal bank |
| mem_off | output | 14 | Offset inside fixed RAM or bank |
| win_void | output | 1 | Window access hits no memory |
| win_rdata | output | 8 | Window read data (0xFF when void) |
| ext_addr | output | 29 | External byte address |
| cs_n | output | 4 | Active-low external chip selects |
| bus_err | output | 1 | Extended access to an unmapped bank |

## Verification
A page-register write and a memory access that depends on that register can fall in the same cycle. The bench therefore often raises `io_wr` together with `cpu_rd` or `cpu_wr`, aimed at ports 0x01, 0x02 and 0x05. The outputs of that cycle are judged against the register values from before the write. The outputs of the next cycle are judged against the newly written value.

// File: rtl/pagemap_ctl.sv
module pagemap_ctl #(
  parameter logic [7:0] LO_PORT  = 8'h01,
  parameter logic [7:0] HI_PORT  = 8'h02,
  parameter logic [7:0] SEL_PORT = 8'h05,
  parameter int         NBANK    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  bank_rdata,
  input  logic        io_wr,
  input  logic [7:0]  io_port,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        fix_sel,
  output logic [6:0]  bank_stb,
  output logic [13:0] mem_off,
  output logic        win_void,
  output logic [7:0]  win_rdata,
  output logic [28:0] ext_addr,
  output logic [3:0]  cs_n,
  output logic        bus_err
);

  logic [7:0] lo_q, sel_q;
  logic [5:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sel_q <= '0;
    end else if (io_wr) begin
      if (io_port == LO_PORT)  lo_q  <= io_wdata;
      if (io_port == HI_PORT)  hi_q  <= io_wdata[5:0];
      if (io_port == SEL_PORT) sel_q <= io_wdata;
    end
  end

  always_comb begin
    if (io_port == LO_PORT)       io_rdata = lo_q;
    else if (io_port == HI_PORT)  io_rdata = {2'b00, hi_q};
    else if (io_port == SEL_PORT) io_rdata = sel_q;
    else                          io_rdata = 8'hFF;
  end

  wire       req     = cpu_rd | cpu_wr;
  wire       win_acc = req & (cpu_addr[15:14] == 2'b01);
  wire       ext_acc = req & cpu_addr[15];
  wire       short_miss = (sel_q == 8'd0) & (cpu_addr[13:12] != 2'b00);
  wire       win_hit = win_acc & (sel_q < 8'(NBANK)) & ~short_miss;
  wire [2:0] ebank   = hi_q[5:3];

  assign fix_sel   = req & (cpu_addr[15:14] == 2'b00);
  assign mem_off   = cpu_addr[13:0];
  assign win_void  = win_acc & ~win_hit;
  assign win_rdata = win_void ? 8'hFF : bank_rdata;
  assign ext_addr  = {hi_q, lo_q, cpu_addr[14:0]};
  assign bus_err   = ext_acc & ebank[2];

  for (genvar b = 0; b < NBANK; b++) begin : g_stb
    assign bank_stb[b] = win_hit & (sel_q == 8'(b));
  end

  for (genvar c = 0; c < 4; c++) begin : g_cs
    assign cs_n[c] = ~(ext_acc & (ebank == 3'(c)));
  end

endmodule

module pagemap_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        io_wr,
  input logic [7:0]  io_port,
  input logic [7:0]  io_wdata,
  input logic        fix_sel,
  input logic [6:0]  bank_stb,
  input logic        win_void,
  input logic [7:0]  win_rdata,
  input logic [28:0] ext_addr,
  input logic [3:0]  cs_n,
  input logic        bus_err
);
  p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bank_stb));
  p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n) $countones(~cs_n) <= 1);
  p_err_no_cs_r8: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> (cs_n == 4'hF));
  p_fixed_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fix_sel |-> (bank_stb == '0 && cs_n == 4'hF && !bus_err && !win_void));
  p_void_ff_r4: assert property (@(posedge clk) disable iff (!rst_n) win_void |-> (win_rdata == 8'hFF));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> (!fix_sel && bank_stb == '0 && cs_n == 4'hF && !bus_err && !win_void));
  p_lo_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_port == 8'h01) |=> (ext_addr[22:15] == $past(io_wdata)));
endmodule

bind pagemap_ctl pagemap_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .io_wr(io_wr),
  .io_port(io_port), .io_wdata(io_wdata), .fix_sel(fix_sel), .bank_stb(bank_stb),
  .win_void(win_void), .win_rdata(win_rdata), .ext_addr(ext_addr), .cs_n(cs_n),
  .bus_err(bus_err)
);

// File: tb/test_pagemap_ctl.sv
module test_pagemap_ctl;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  bank_rdata = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = '0, io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        fix_sel;
  logic [6:0]  bank_stb;
  logic [13:0] mem_off;
  logic        win_void;
  logic [7:0]  win_rdata;
  logic [28:0] ext_addr;
  logic [3:0]  cs_n;
  logic        bus_err;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_lo = '0, m_sel = '0;
  logic [5:0] m_hi = '0;

  pagemap_ctl i_pagemap_ctl (.*);

  always #(TCLK/2) clk = ~clk;

  initial begin
    #(TCLK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [83:0] expect_out();
    logic        req, fx, wa, ea, hit;
    logic [6:0]  stb;
    logic [3:0]  cs;
    logic [2:0]  eb;
    req = cpu_rd | cpu_wr;
    fx  = req && cpu_addr < 16'h4000;
    wa  = req && cpu_addr >= 16'h4000 && cpu_addr < 16'h8000;
    ea  = req && cpu_addr >= 16'h8000;
    hit = wa && m_sel <= 8'd6 && !(m_sel == 8'd0 && cpu_addr >= 16'h5000);
    stb = hit ? 7'(1 << m_sel) : 7'd0;
    eb  = m_hi[5:3];
    cs  = (ea && eb < 3'd4) ? ~4'(1 << eb) : 4'hF;
    return {fx, stb, cpu_addr[13:0], wa && !hit, (wa && !hit) ? 8'hFF : bank_rdata,
            m_hi, m_lo, cpu_addr[14:0], cs, ea && eb >= 3'd4};
  endfunction

  function automatic logic [7:0] expect_io(logic [7:0] p);
    case (p)
      8'h01:   return m_lo;
      8'h02:   return {2'b00, m_hi};
      8'h05:   return m_sel;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of();
    if (!(cpu_rd | cpu_wr)) return "R10";
    if (cpu_addr < 16'h4000) return "R2";
    if (cpu_addr < 16'h8000) begin
      if (m_sel >= 8'd7) return "R5";
      if (m_sel == 8'd0 && cpu_addr >= 16'h5000) return "R4";
      return "R3";
    end
    if (m_hi[5:3] >= 3'd4) return "R8";
    return "R6/R7";
  endfunction

  task automatic check_now(string forced);
    logic [83:0] act, exp;
    string t;
    #1;
    exp = expect_out();
    act = {fix_sel, bank_stb, mem_off, win_void, win_rdata, ext_addr, cs_n, bus_err};
    t = (forced != "") ? forced : tag_of();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", t, cpu_addr, act, exp);
    end
    n_chk++;
    if (io_rdata !== expect_io(io_port)) begin
      n_bad++;
      $display("FAIL R9: port=%h actual=%h expected=%h", io_port, io_rdata, expect_io(io_port));
    end
  endtask

  task automatic step(logic [15:0] a, logic rd, logic wr, logic iw, logic [7:0] p,
                      logic [7:0] d, string forced);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    io_wr = iw; io_port = p; io_wdata = d;
    bank_rdata = 8'($urandom);
    check_now(forced);
    if (iw) begin
      if (p == 8'h01) m_lo = d;
      if (p == 8'h02) m_hi = d[5:0];
      if (p == 8'h05) m_sel = d;
    end
  endtask

  task automatic io_set(logic [7:0] p, logic [7:0] d);
    step(16'h0000, 1'b0, 1'b0, 1'b1, p, d, "R9");
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset values via readback
    step(16'h0000, 0, 0, 0, 8'h01, 0, "R1");
    step(16'h0000, 0, 0, 0, 8'h02, 0, "R1");
    step(16'h0000, 0, 0, 0, 8'h05, 0, "R1");
    // R7: directed external addresses 0x04000000 and 0x08000000
    io_set(8'h02, 8'h08); io_set(8'h01, 8'h00);
    step(16'h8000, 1, 0, 0, 8'h02, 0, "R7");
    n_chk++;
    if (cs_n !== 4'b1101 || ext_addr !== 29'h04000000) begin
      n_bad++; $display("FAIL R7: cs_n=%b ext=%h expected 1101 04000000", cs_n, ext_addr);
    end
    io_set(8'h02, 8'hD0);
    step(16'h8000, 0, 1, 0, 8'h02, 0, "R7");
    n_chk++;
    if (cs_n !== 4'b1011) begin
      n_bad++; $display("FAIL R7: cs_n=%b expected 1011", cs_n);
    end
    // R8: bank 5
    io_set(8'h02, 8'h28);
    step(16'hFFFF, 1, 0, 0, 8'h00, 0, "R8");
    // R4: USB bank edges
    io_set(8'h05, 8'h00);
    step(16'h4FFF, 1, 0, 0, 8'h05, 0, "R3");
    step(16'h5000, 1, 0, 0, 8'h05, 0, "R4");
    // R5: code 7 and 255
    io_set(8'h05, 8'h07);
    step(16'h4000, 1, 0, 0, 8'h05, 0, "R5");
    io_set(8'h05, 8'hFF);
    step(16'h7FFF, 0, 1, 0, 8'h05, 0, "R5");
    // R9: write and dependent access in same cycle, then next cycle
    step(16'h6000, 1, 0, 1, 8'h05, 8'h03, "R9");
    step(16'h6000, 1, 0, 0, 8'h05, 0, "R9");
    // R2: fixed region with extreme pages
    step(16'h3FFF, 1, 0, 0, 8'h33, 0, "R2");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  p, d;
      logic        iw, rd, wr;
      a  = 16'($urandom);
      rd = ($urandom % 3) != 0;
      wr = !rd && ($urandom % 2);
      iw = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: p = 8'h01;
        1: p = 8'h02;
        2: p = 8'h05;
        3: p = 8'h05;
        default: p = 8'($urandom);
      endcase
      d = (p == 8'h05) ? 8'($urandom % 10) : 8'($urandom);
      step(a, rd, wr, iw, p, d, "");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule